// File: doc/BRIEF.md
# Cross-Clock Line Ring Video Buffer

This block moves picture data from a source raster running on one clock to an output raster running on another clock. It stores whole source lines in a small ring of line slots held in one dual-port RAM. The source side writes only its active pixels. It counts its own columns and lines from a start-of-frame marker. The output side counts its own raster position. It places the source picture at a fixed vertical and horizontal offset inside the output frame, and reads pixels only inside that placed window. Every other output pixel is black.

Each side publishes how many source lines it has finished, either written or read. These counts cross to the other clock as Gray code through a two-flop synchroniser. The write side uses the read count to detect a lap of the ring, and latches an overflow flag. The read side uses the write count to detect a fetch of an incomplete line, and latches an underflow flag. The ring depth, the picture size and the placement offsets are fixed when the block is built.

The write controller has four states. W_IDLE waits for the first frame. W_LINE takes pixels of the current line. W_GAP is the blanking between lines. W_DONE holds after the last active line of a frame. Its transitions are:
- any state to W_LINE on a start-of-frame pixel
- W_LINE to W_GAP when the enable falls on a line that is not the last
- W_LINE to W_DONE when the enable falls on the last line
- W_GAP to W_LINE when the enable rises

The read controller has three states. R_IDLE waits for the first output frame. R_ACT is inside an output active line. R_HBL is output line blanking. Its transitions are:
- any state to R_ACT on an output start-of-frame pixel
- R_ACT to R_HBL when the output enable falls, which also advances the output line
- R_HBL to R_ACT when the output enable rises

Top module: `xclk_line_ring`

## Requirements
- R1: After reset, out_pix is 0 and both ovf_flag and udf_flag are low.
- R2: A source pixel is stored only if three conditions hold: src_de is high, it lies in columns 0..ACT_W-1, and it lies in lines 0..ACT_H-1 counted from the src_sof pixel (line 0, column 0). Blanking pixels are never stored, and neither are extra columns or extra lines. None of them alters any stored line.
- R3: The output position is (0,0) on the out_sof pixel. x advances on each out_de cycle. y advances and x returns to 0 when out_de falls. When y lies in VOFF..VOFF+ACT_H-1 and x lies in HOFF..HOFF+ACT_W-1, out_pix shows source pixel (line y-VOFF, column x-HOFF) one rd_clk cycle after that output pixel is presented.
- R4: One rd_clk after a pixel that lies outside the placed window, or after a cycle with out_de low, out_pix is 0.
- R5: Source line L occupies slot L mod RING. RING consecutive lines coexist, so the writer may run RING-1 lines ahead of the lines already read without loss and without raising ovf_flag.
- R6: ovf_flag is set when a pixel of source line L is written while L >= (lines fully read in the current output frame) + RING.
- R7: udf_flag is set when a pixel of source line L is fetched while L >= (lines fully written in the current source frame).
- R8: Both flags are sticky. ovf_flag is cleared only by wr_rst_n and udf_flag only by rd_rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source pixel clock |
| wr_rst_n | input | 1 | Active-low reset, source domain |
| src_de | input | 1 | Source active-video enable |
| src_sof | input | 1 | Marks the first active source pixel of a frame (with src_de) |
| src_pix | input | PIX_W | Source pixel value |
| rd_clk | input | 1 | Output pixel clock |
| rd_rst_n | input | 1 | Active-low reset, output domain |
| out_de | input | 1 | Output active-video enable |
| out_sof | input | 1 | Marks the first active output pixel of a frame (with out_de) |
| out_pix | output | PIX_W | Output pixel, black outside the placed picture |
| ovf_flag | output | 1 | Sticky ring overrun flag (source domain) |
| udf_flag | output | 1 | Sticky ring starvation flag (output domain) |

## Verification
The cases that matter are the cycles where a slot fetch and the underflow judgment fall together on the same pixel. A fetch of line 0 right after it completes must not raise udf_flag. The next line, which is still unwritten, must raise it. In the same way, a source write and the overflow judgment fall together on one pixel. The bench writes exactly RING-1 lines ahead of the read progress and expects ovf_flag low. It then writes one line more and expects the flag high. The main sweep walks every output pixel of a frame, checking each pixel against an arithmetic pixel code. In that sweep, extra columns, extra lines and blanking values are aimed at slots that still hold unread lines, so any stray write shows up as a wrong pixel.

// File: rtl/lr_pkg.sv
package lr_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_LINE,
        W_GAP,
        W_DONE
    } wr_state_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_ACT,
        R_HBL
    } rd_state_e;

endpackage

// File: rtl/lr_dpram.sv
module lr_dpram #(
    parameter int DW    = 12,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re && (32'(raddr) < DEPTH)) rdata <= mem[raddr];
    end
endmodule

// File: rtl/lr_gray_sync.sv
module lr_gray_sync #(
    parameter int W = 4
) (
    input  logic         s_clk,
    input  logic         s_rst_n,
    input  logic [W-1:0] s_bin,
    input  logic         d_clk,
    input  logic         d_rst_n,
    output logic [W-1:0] d_bin
);
    logic [W-1:0] s_gray;
    logic [W-1:0] d_meta;
    logic [W-1:0] d_gray;

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_ff @(posedge s_clk or negedge s_rst_n) begin
        if (!s_rst_n) s_gray <= '0;
        else          s_gray <= s_bin ^ (s_bin >> 1);
    end

    always_ff @(posedge d_clk or negedge d_rst_n) begin
        if (!d_rst_n) begin
            d_meta <= '0;
            d_gray <= '0;
        end else begin
            d_meta <= s_gray;
            d_gray <= d_meta;
        end
    end

    always_comb d_bin = gray_to_bin(d_gray);
endmodule

// File: rtl/lr_wr_ctrl.sv
module lr_wr_ctrl
    import lr_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int ACT_W = 64,
    parameter int ACT_H = 48,
    parameter int RING  = 4,
    parameter int AW    = 8,
    parameter int LW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_de,
    input  logic             src_sof,
    input  logic [PIX_W-1:0] src_pix,
    input  logic [LW-1:0]    rd_done,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PIX_W-1:0] wdata,
    output logic [LW-1:0]    lines_done,
    output logic             ovf
);
    localparam int CW = $clog2(ACT_W + 1);

    wr_state_e      state, nxt;
    logic [CW-1:0]  wcol;
    logic [LW-1:0]  wline;
    logic [CW-1:0]  cur_col;
    logic [LW-1:0]  cur_line;
    logic           sof_ok;
    logic           take;
    logic           ovf_hit;

    // next-state process
    always_comb begin
        sof_ok = src_sof && src_de;
        nxt    = state;
        unique case (state)
            W_IDLE: nxt = W_IDLE;
            W_LINE: if (!src_de) nxt = (32'(wline) + 1 == ACT_H) ? W_DONE : W_GAP;
            W_GAP:  if (src_de)  nxt = W_LINE;
            W_DONE: nxt = W_DONE;
            default: nxt = W_IDLE;
        endcase
        if (sof_ok) nxt = W_LINE;
    end

    // output process
    always_comb begin
        cur_col    = sof_ok ? '0 : wcol;
        cur_line   = sof_ok ? '0 : wline;
        take       = src_de && (sof_ok || state == W_LINE || state == W_GAP);
        we         = take && (32'(cur_col) < ACT_W);
        waddr      = AW'((32'(cur_line) % RING) * ACT_W + 32'(cur_col));
        wdata      = src_pix;
        ovf_hit    = we && (32'(cur_line) >= 32'(rd_done) + RING);
        lines_done = wline;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= W_IDLE;
            wcol  <= '0;
            wline <= '0;
            ovf   <= 1'b0;
        end else begin
            state <= nxt;
            if (sof_ok) begin
                wcol  <= CW'(1);
                wline <= '0;
            end else if (state == W_LINE) begin
                if (src_de) begin
                    if (32'(wcol) < ACT_W) wcol <= wcol + 1'b1;
                end else begin
                    wcol  <= '0;
                    wline <= wline + 1'b1;
                end
            end else if (state == W_GAP && src_de) begin
                wcol <= CW'(1);
            end
            if (ovf_hit) ovf <= 1'b1;
        end
    end

    // R2
    wline_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wline) <= ACT_H);

    // R2
    done_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_DONE) |-> (32'(wline) == ACT_H));

    // R5
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(waddr) < RING * ACT_W));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

// File: rtl/lr_rd_ctrl.sv
module lr_rd_ctrl
    import lr_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int ACT_W = 64,
    parameter int ACT_H = 48,
    parameter int RING  = 4,
    parameter int AW    = 8,
    parameter int LW    = 6,
    parameter int OCW   = 12,
    parameter int VOFF  = 8,
    parameter int HOFF  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_de,
    input  logic             out_sof,
    input  logic [LW-1:0]    wr_done,
    output logic             re,
    output logic [AW-1:0]    raddr,
    input  logic [PIX_W-1:0] rdata,
    output logic [PIX_W-1:0] out_pix,
    output logic [LW-1:0]    rd_done,
    output logic             udf
);
    rd_state_e      state, nxt;
    logic [OCW-1:0] xcnt, ycnt;
    logic [OCW-1:0] cur_x, cur_y;
    logic           sof_ok;
    logic           started;
    logic           win;
    logic           win_q;
    logic           last_col;
    logic [LW-1:0]  rd_line;
    logic [31:0]    rd_col;

    // next-state process
    always_comb begin
        sof_ok = out_sof && out_de;
        nxt    = state;
        unique case (state)
            R_IDLE: nxt = R_IDLE;
            R_ACT:  if (!out_de) nxt = R_HBL;
            R_HBL:  if (out_de)  nxt = R_ACT;
            default: nxt = R_IDLE;
        endcase
        if (sof_ok) nxt = R_ACT;
    end

    // output process
    always_comb begin
        cur_x    = sof_ok ? '0 : xcnt;
        cur_y    = sof_ok ? '0 : ycnt;
        started  = sof_ok || (state != R_IDLE);
        win      = out_de && started
                   && (32'(cur_y) >= 32'(VOFF)) && (32'(cur_y) < 32'(VOFF + ACT_H))
                   && (32'(cur_x) >= 32'(HOFF)) && (32'(cur_x) < 32'(HOFF + ACT_W));
        rd_line  = LW'(32'(cur_y) - 32'(VOFF));
        rd_col   = 32'(cur_x) - 32'(HOFF);
        last_col = (rd_col == 32'(ACT_W - 1));
        re       = win;
        raddr    = AW'((32'(rd_line) % RING) * ACT_W + rd_col);
        out_pix  = win_q ? rdata : '0;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= R_IDLE;
            xcnt    <= '0;
            ycnt    <= '0;
            rd_done <= '0;
            udf     <= 1'b0;
            win_q   <= 1'b0;
        end else begin
            state <= nxt;
            win_q <= win;
            if (sof_ok) begin
                xcnt <= OCW'(1);
                ycnt <= '0;
            end else if (state == R_ACT) begin
                if (out_de) begin
                    xcnt <= xcnt + 1'b1;
                end else begin
                    xcnt <= '0;
                    ycnt <= ycnt + 1'b1;
                end
            end else if (state == R_HBL && out_de) begin
                xcnt <= xcnt + 1'b1;
            end
            if (win && last_col)  rd_done <= rd_line + 1'b1;
            else if (sof_ok)      rd_done <= '0;
            if (win && (32'(rd_line) >= 32'(wr_done))) udf <= 1'b1;
        end
    end

    // R4
    black_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |=> (out_pix == '0));

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf |=> udf);

    // R3
    rd_done_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_sof |=> (rd_done >= $past(rd_done)));

    // R5
    rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        re |-> (32'(raddr) < RING * ACT_W));
endmodule

// File: rtl/xclk_line_ring.sv
module xclk_line_ring #(
    parameter int PIX_W = 12,
    parameter int ACT_W = 64,
    parameter int ACT_H = 48,
    parameter int RING  = 4,
    parameter int OCW   = 12,
    parameter int VOFF  = 8,
    parameter int HOFF  = 16
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             src_de,
    input  logic             src_sof,
    input  logic [PIX_W-1:0] src_pix,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             out_de,
    input  logic             out_sof,
    output logic [PIX_W-1:0] out_pix,
    output logic             ovf_flag,
    output logic             udf_flag
);
    localparam int DEPTH = RING * ACT_W;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW    = $clog2(ACT_H + 1);

    logic             we, re;
    logic [AW-1:0]    waddr, raddr;
    logic [PIX_W-1:0] wdata, rdata;
    logic [LW-1:0]    wr_lines_w, wr_lines_r;
    logic [LW-1:0]    rd_lines_r, rd_lines_w;

    lr_wr_ctrl #(
        .PIX_W(PIX_W), .ACT_W(ACT_W), .ACT_H(ACT_H), .RING(RING), .AW(AW), .LW(LW)
    ) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .src_de(src_de), .src_sof(src_sof), .src_pix(src_pix),
        .rd_done(rd_lines_w),
        .we(we), .waddr(waddr), .wdata(wdata),
        .lines_done(wr_lines_w), .ovf(ovf_flag)
    );

    lr_rd_ctrl #(
        .PIX_W(PIX_W), .ACT_W(ACT_W), .ACT_H(ACT_H), .RING(RING), .AW(AW), .LW(LW),
        .OCW(OCW), .VOFF(VOFF), .HOFF(HOFF)
    ) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .out_de(out_de), .out_sof(out_sof),
        .wr_done(wr_lines_r),
        .re(re), .raddr(raddr), .rdata(rdata),
        .out_pix(out_pix), .rd_done(rd_lines_r), .udf(udf_flag)
    );

    lr_dpram #(.DW(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(rdata)
    );

    lr_gray_sync #(.W(LW)) u_w2r (
        .s_clk(wr_clk), .s_rst_n(wr_rst_n), .s_bin(wr_lines_w),
        .d_clk(rd_clk), .d_rst_n(rd_rst_n), .d_bin(wr_lines_r)
    );

    lr_gray_sync #(.W(LW)) u_r2w (
        .s_clk(rd_clk), .s_rst_n(rd_rst_n), .s_bin(rd_lines_r),
        .d_clk(wr_clk), .d_rst_n(wr_rst_n), .d_bin(rd_lines_w)
    );
endmodule

// File: tb/sim_xclk_line_ring.sv
module sim_xclk_line_ring;
    localparam int PW = 12;
    localparam int AWD = 5;
    localparam int AHT = 6;
    localparam int RG = 3;
    localparam int VO = 2;
    localparam int HO = 1;
    localparam int OW = 8;
    localparam int OH = 10;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic src_de = 0, src_sof = 0;
    logic [PW-1:0] src_pix = '0;
    logic out_de = 0, out_sof = 0;
    logic [PW-1:0] out_pix;
    logic ovf_flag, udf_flag;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #14 wr_clk = ~wr_clk;
    always #10 rd_clk = ~rd_clk;   // 50 MHz

    xclk_line_ring #(
        .PIX_W(PW), .ACT_W(AWD), .ACT_H(AHT), .RING(RG), .OCW(6), .VOFF(VO), .HOFF(HO)
    ) u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .src_de(src_de), .src_sof(src_sof),
        .src_pix(src_pix), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_de(out_de),
        .out_sof(out_sof), .out_pix(out_pix), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    function automatic logic [PW-1:0] pv(int fid, int l, int c);
        return PW'(fid * 256 + l * 16 + c + 1);
    endfunction

    task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge wr_clk);
        repeat (8) @(posedge rd_clk);
    endtask

    // one source line; columns beyond AWD carry a marker value
    task automatic src_line(int fid, int l, int ncols, bit sof);
        for (int c = 0; c < ncols; c++) begin
            @(negedge wr_clk);
            src_de  = 1;
            src_sof = sof && (c == 0);
            src_pix = (c < AWD) ? pv(fid, l, c) : 12'hEEE;
        end
        @(negedge wr_clk);
        src_de = 0; src_sof = 0; src_pix = 12'hBAD;
        @(negedge wr_clk); src_pix = 12'hFFF;
        @(negedge wr_clk); src_pix = 12'h5A5;
    endtask

    function automatic logic [PW-1:0] expect_px(int fid, int x, int y);
        if (y >= VO && y < VO + AHT && x >= HO && x < HO + AWD)
            return pv(fid, y - VO, x - HO);
        return '0;
    endfunction

    function automatic string req_of(int x, int y);
        if (y >= VO && y < VO + AHT && x >= HO && x < HO + AWD) return "R2 R3 R5";
        return "R4";
    endfunction

    // one output line; checks each pixel one rd_clk after it is presented
    task automatic out_line(int y, bit sof, int fid, bit chk_en);
        for (int x = 0; x < OW; x++) begin
            @(negedge rd_clk);
            if (x > 0 && chk_en)
                chk(req_of(x - 1, y), out_pix, expect_px(fid, x - 1, y),
                    $sformatf("pixel x=%0d y=%0d", x - 1, y));
            out_de  = 1;
            out_sof = sof && (x == 0);
        end
        @(negedge rd_clk);
        if (chk_en)
            chk(req_of(OW - 1, y), out_pix, expect_px(fid, OW - 1, y),
                $sformatf("pixel x=%0d y=%0d", OW - 1, y));
        out_de = 0; out_sof = 0;
        repeat (2) @(negedge rd_clk);
        if (chk_en) chk("R4", out_pix, '0, "blank after line");
    endtask

    initial begin
        repeat (4) @(negedge rd_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (3) @(negedge rd_clk);
        // R1
        chk("R1", out_pix, '0, "out_pix after reset");
        chk("R1", PW'(ovf_flag), '0, "ovf after reset");
        chk("R1", PW'(udf_flag), '0, "udf after reset");

        // main frame: prefill RG lines, each with two extra columns (R2)
        src_line(1, 0, AWD + 2, 1);
        src_line(1, 1, AWD + 2, 0);
        src_line(1, 2, AWD + 2, 0);
        settle();
        out_line(0, 1, 1, 1);
        out_line(1, 0, 1, 1);
        for (int k = 0; k < AHT; k++) begin
            settle();
            out_line(VO + k, 0, 1, 1);
            settle();
            if (k + RG < AHT) src_line(1, k + RG, AWD + 2, 0);
            // R2: a line past AHT would land on the slot of unread line 3
            if (k + RG == AHT - 1) src_line(14, AHT, AWD, 0);
        end
        for (int y = VO + AHT; y < OH; y++) out_line(y, 0, 1, 1);
        settle();
        // R5: running RG-1 lines ahead raised no overflow; no starvation either
        chk("R5", PW'(ovf_flag), '0, "ovf after clean frame");
        chk("R7", PW'(udf_flag), '0, "udf after clean frame");

        // underflow: only line 0 of frame 2 exists
        src_line(2, 0, AWD, 1);
        settle();
        out_line(0, 1, 2, 1);
        out_line(1, 0, 2, 1);
        out_line(2, 0, 2, 1);
        settle();
        chk("R7", PW'(udf_flag), '0, "udf after reading a completed line");
        out_line(3, 0, 2, 0);
        settle();
        chk("R7", PW'(udf_flag), 1, "udf after reading unwritten line");

        // overflow: two lines fully read, write up to line 4 then line 5
        for (int l = 1; l <= 4; l++) src_line(2, l, AWD, 0);
        settle();
        chk("R6", PW'(ovf_flag), '0, "ovf at RG-1 lines ahead");
        src_line(2, 5, AWD, 0);
        settle();
        chk("R6", PW'(ovf_flag), 1, "ovf at RG lines ahead");

        // R8: sticky and domain-local clearing
        out_line(4, 0, 2, 0);
        settle();
        chk("R8", PW'(ovf_flag), 1, "ovf held");
        chk("R8", PW'(udf_flag), 1, "udf held");
        @(negedge rd_clk); rd_rst_n = 0;
        @(negedge rd_clk); rd_rst_n = 1;
        settle();
        chk("R8", PW'(udf_flag), '0, "udf after read reset");
        chk("R8", PW'(ovf_flag), 1, "ovf unaffected by read reset");
        @(negedge wr_clk); wr_rst_n = 0;
        @(negedge wr_clk); wr_rst_n = 1;
        settle();
        chk("R8", PW'(ovf_flag), '0, "ovf after write reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule